// File: doc/BRIEF.md
# Synchronous Slave FIFO Write Master

This block moves 32-bit words from a local producer into an external synchronous slave FIFO, such as the receive buffer of a USB bridge device. The local side offers words through a valid/ready handshake. The device side gets a data bus and an active-low write strobe. The device reports back through an active-low "almost full" flag.

That flag is slow. It shows the buffer state only after a fixed number of clocks, and the device raises it early, at a programmable watermark of free slots. The controller's job is to stop writing after a small, fixed number of words once the flag drops, and to resume when the flag rises again. Every accepted word must appear on the device bus exactly once and in order.

The system integrator chooses the device watermark. It must cover the flag delay plus the controller's own stop distance, which is a function of the `FLAG_STAGES` parameter. With that margin in place, the device buffer never overflows and no word is lost.

Top module: `sfw_master`

## Requirements
- R1: While `rst_n` is low, `dev_wr_n` is high (no write). With `FLAG_STAGES`=1, `src_ready` is also low during reset.
- R2: `dev_pfull_n` low means the device has no room to spare. With `FLAG_STAGES`=1, `src_ready` equals the value of `dev_pfull_n` sampled at the previous clock edge. With `FLAG_STAGES`=0, `src_ready` follows `dev_pfull_n` directly.
- R3: `dev_wr_n` is low (a write) in the cycle right after each edge at which `src_valid` and `src_ready` are both high. It is high in every other cycle.
- R4: During each write, `dev_data` carries the `src_data` word that was accepted at the previous edge.
- R5: When no write is issued, `dev_data` keeps the last accepted word unchanged.
- R6: While `dev_pfull_n` stays low, the device samples at most `FLAG_STAGES`+1 writes. With a source that is always valid, the count is exactly `FLAG_STAGES`+1.
- R7: When `dev_pfull_n` rises again, writing resumes with the next source word. No word is skipped or repeated across a stall.
- R8: Suppose the device's flag is delayed by LAT cycles and its watermark is at least LAT+`FLAG_STAGES`+2 free slots. Then the device buffer never receives a write while it is full.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock shared with the device interface |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_valid | input | 1 | Local producer offers a word |
| src_data | input | DATA_W | Word offered by the local producer |
| src_ready | output | 1 | Controller accepts the offered word at this edge |
| dev_data | output | DATA_W | Data bus to the external FIFO |
| dev_wr_n | output | 1 | Active-low write strobe to the external FIFO |
| dev_pfull_n | input | 1 | Active-low almost-full flag from the external FIFO |

## Verification
The bench streams a numbered sequence into a device model. The model's flag trails its occupancy by three cycles and uses a watermark. The model's drain behaviour is switched between no drain, steady drain, slow drain and a full-packet commit that empties the buffer at once.

- **Stall against an undrained buffer.** The bench counts the writes that land after the flag drops. A controller that ignores the flag, or adds a register stage, pushes past `FLAG_STAGES`+1 and overflows the model.
- **Resume after a stall.** Each arriving number is compared with the scoreboard queue. A design that re-presents a written word, or drops the word held when ready fell, shows up as a duplicate or a gap.
- **Bus value during idle cycles.** The bench also checks the bus during idle cycles, which catches a data register that loads without a handshake.

// File: rtl/sfw_pkg.sv
package sfw_pkg;

    // Default width of the device data bus.
    localparam int WORD_W = 32;

    // Number of strobes the device can still sample after its flag
    // has dropped, for a given count of flag register stages.
    function automatic int stop_distance(input int flag_stages);
        return flag_stages + 1;
    endfunction

endpackage

// File: rtl/sfw_flag_stage.sv
module sfw_flag_stage #(
    parameter int FLAG_STAGES = 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic flag_n_in,
    output logic room_ok
);

    generate
        if (FLAG_STAGES == 0) begin : g_direct
            // Room follows the device pin combinationally.
            assign room_ok = flag_n_in;
        end else begin : g_registered
            // One register between pin and handshake; resets to "no room"
            // so nothing is accepted before the flag has been seen.
            logic room_d, room_q;

            always_comb begin
                room_d = flag_n_in;
            end

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) room_q <= 1'b0;
                else        room_q <= room_d;
            end

            assign room_ok = room_q;
        end
    endgenerate

endmodule

// File: rtl/sfw_launch.sv
module sfw_launch #(
    parameter int DATA_W = sfw_pkg::WORD_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [DATA_W-1:0] load_data,
    output logic              wr_active,
    output logic [DATA_W-1:0] bus_data
);

    typedef struct packed {
        logic              wr;
        logic [DATA_W-1:0] data;
    } launch_t;

    launch_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        st_d.wr = load;
        if (load) begin
            st_d.data = load_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.wr   <= 1'b0;
            st_q.data <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign wr_active = st_q.wr;
    assign bus_data  = st_q.data;

endmodule

// File: rtl/sfw_master.sv
module sfw_master #(
    parameter int DATA_W      = sfw_pkg::WORD_W,
    parameter int FLAG_STAGES = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              src_valid,
    input  logic [DATA_W-1:0] src_data,
    output logic              src_ready,
    output logic [DATA_W-1:0] dev_data,
    output logic              dev_wr_n,
    input  logic              dev_pfull_n
);

    localparam int STOP_DIST = sfw_pkg::stop_distance(FLAG_STAGES);

    logic room_ok;
    logic take;
    logic wr_active;

    sfw_flag_stage #(
        .FLAG_STAGES (FLAG_STAGES)
    ) flag_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .flag_n_in (dev_pfull_n),
        .room_ok   (room_ok)
    );

    // A word is taken only when the (possibly delayed) flag shows room;
    // a taken word is always written on the next cycle.
    always_comb begin
        src_ready = room_ok;
        take      = src_valid && room_ok;
    end

    sfw_launch #(
        .DATA_W (DATA_W)
    ) launch_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (take),
        .load_data (src_data),
        .wr_active (wr_active),
        .bus_data  (dev_data)
    );

    assign dev_wr_n = ~wr_active;

    initial begin
        if (STOP_DIST < 1 || FLAG_STAGES > 1) begin
            $display("sfw_master: FLAG_STAGES must be 0 or 1");
        end
    end

endmodule

// File: rtl/sfw_master_chk.sv
module sfw_master_chk #(
    parameter int DATA_W      = sfw_pkg::WORD_W,
    parameter int FLAG_STAGES = 1
) (
    input logic              clk,
    input logic              rst_n,
    input logic              src_valid,
    input logic [DATA_W-1:0] src_data,
    input logic              src_ready,
    input logic [DATA_W-1:0] dev_data,
    input logic              dev_wr_n,
    input logic              dev_pfull_n
);

    localparam int STOP_DIST = sfw_pkg::stop_distance(FLAG_STAGES);

    logic       seen_q;
    logic [7:0] low_writes_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seen_q       <= 1'b0;
            low_writes_q <= '0;
        end else begin
            seen_q <= 1'b1;
            if (dev_pfull_n)        low_writes_q <= '0;
            else if (!dev_wr_n && low_writes_q != 8'hFF)
                                    low_writes_q <= low_writes_q + 8'd1;
        end
    end

    // R1: idle strobe (and closed ready when registered) during reset
    always @(posedge clk) begin
        if (!rst_n) begin
            a_r1_reset_idle: assert (dev_wr_n && (FLAG_STAGES == 0 || !src_ready))
                else $error("R1 violated");
        end
    end

    generate
        if (FLAG_STAGES != 0) begin : g_reg_flag
            // R2: ready is the flag seen one edge earlier
            a_r2_ready_follows_flag: assert property (@(posedge clk) disable iff (!rst_n)
                seen_q |-> (src_ready == $past(dev_pfull_n)));
        end else begin : g_dir_flag
            // R2: ready follows the flag directly
            a_r2_ready_follows_flag: assert property (@(posedge clk) disable iff (!rst_n)
                src_ready == dev_pfull_n);
        end
    endgenerate

    // R3: every handshake yields one write on the next cycle
    a_r3_write_after_take: assert property (@(posedge clk) disable iff (!rst_n)
        (src_valid && src_ready) |=> !dev_wr_n);

    // R3: no write without a handshake
    a_r3_no_spurious_write: assert property (@(posedge clk) disable iff (!rst_n)
        !(src_valid && src_ready) |=> dev_wr_n);

    // R4: the written word is the accepted word
    a_r4_data_matches: assert property (@(posedge clk) disable iff (!rst_n)
        (src_valid && src_ready) |=> (dev_data == $past(src_data)));

    // R5: bus holds its value when nothing is accepted
    a_r5_bus_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !(src_valid && src_ready) |=> $stable(dev_data));

    // R6: bounded writes while the flag stays low
    a_r6_stop_distance: assert property (@(posedge clk) disable iff (!rst_n)
        low_writes_q <= 8'(STOP_DIST));

endmodule

bind sfw_master sfw_master_chk #(
    .DATA_W      (DATA_W),
    .FLAG_STAGES (FLAG_STAGES)
) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .src_valid   (src_valid),
    .src_data    (src_data),
    .src_ready   (src_ready),
    .dev_data    (dev_data),
    .dev_wr_n    (dev_wr_n),
    .dev_pfull_n (dev_pfull_n)
);

// File: tb/sfw_master_tb.sv
module sfw_master_tb_top;

    localparam int DATA_W = 32;
    localparam int FSTG   = 1;
    localparam int POST   = FSTG + 1;
    localparam int LAT    = 3;
    localparam int CAP    = 32;
    localparam int WM     = LAT + POST + 2;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              src_valid = 1'b0;
    logic [DATA_W-1:0] src_data = '0;
    logic              src_ready;
    logic [DATA_W-1:0] dev_data;
    logic              dev_wr_n;
    logic              dev_pfull_n;

    always #4 clk = ~clk;

    sfw_master #(.DATA_W(DATA_W), .FLAG_STAGES(FSTG)) dut_i (
        .clk(clk), .rst_n(rst_n), .src_valid(src_valid), .src_data(src_data),
        .src_ready(src_ready), .dev_data(dev_data), .dev_wr_n(dev_wr_n),
        .dev_pfull_n(dev_pfull_n)
    );

    int tests = 0;
    int fails = 0;
    logic [DATA_W-1:0] exp_q[$];
    int unsigned seq = 1;
    int unsigned last_acc = 0;
    int sent = 0;

    // device model state
    int occ = 0;
    int overflows = 0;
    int mismatches = 0;
    int hold_viol = 0;
    int received = 0;
    int run = 0;
    int max_run = 0;
    int drain_mode = 0;
    int tick = 0;
    int commit_cnt = 0;
    logic [LAT-1:0] fl_pipe;
    logic have_written = 1'b0;
    logic [DATA_W-1:0] last_written = '0;

    assign dev_pfull_n = fl_pipe[LAT-1];

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Device buffer and monitor: compares each written word with the queue
    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            occ <= 0; fl_pipe <= '1; run <= 0; tick <= 0; commit_cnt <= 0;
        end else begin
            int nocc;
            nocc = occ;
            tick <= tick + 1;
            if (!dev_wr_n) begin
                if (occ >= CAP) overflows++;
                else nocc = nocc + 1;
                received++;
                if (exp_q.size() == 0) begin
                    mismatches++;
                    $display("[TB] unexpected word %0d", dev_data);
                end else begin
                    logic [DATA_W-1:0] e;
                    e = exp_q.pop_front();
                    if (e != dev_data) begin
                        mismatches++;
                        $display("[TB] word mismatch got %0d want %0d", dev_data, e);
                    end
                end
                have_written = 1'b1;
                last_written = dev_data;
            end else if (have_written && dev_data != last_written) begin
                hold_viol++;
            end
            if (dev_pfull_n) run <= 0;
            else if (!dev_wr_n) begin
                run <= run + 1;
                if (run + 1 > max_run) max_run = run + 1;
            end
            if (occ > 0) begin
                if (drain_mode == 1) nocc = nocc - 1;
                else if (drain_mode == 2 && (tick % 4) == 0) nocc = nocc - 1;
            end
            if (drain_mode == 3 && !dev_pfull_n) begin
                if (commit_cnt == 6) begin
                    nocc = dev_wr_n ? 0 : 1;
                    commit_cnt <= 0;
                end else commit_cnt <= commit_cnt + 1;
            end
            occ <= nocc;
            fl_pipe <= {fl_pipe[LAT-2:0], ((CAP - nocc) > WM)};
        end
    end

    // Driver: offers numbered words, pushes each accepted one to the queue
    task automatic send(input int n, input int gap_pct);
        int done = 0;
        while (done < n) begin
            @(negedge clk);
            if (($urandom % 100) < gap_pct) begin
                src_valid = 1'b0;
            end else begin
                src_valid = 1'b1;
                src_data  = seq;
                if (src_ready) begin
                    exp_q.push_back(seq);
                    last_acc = seq;
                    seq++;
                    done++;
                    sent++;
                end
            end
        end
        @(negedge clk);
        src_valid = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        tests++;
        fails++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(dev_wr_n == 1'b1, "R1 strobe idle in reset", dev_wr_n, 1);
        chk(src_ready == 1'b0, "R1 ready low in reset", src_ready, 0);
        rst_n = 1'b1;
        @(negedge clk);
        @(negedge clk);
        chk(src_ready == 1'b1, "R2 ready after flag seen high", src_ready, 1);
        chk(dev_wr_n == 1'b1, "R3 no write without handshake", dev_wr_n, 1);

        // Scenario 1: undrained buffer, always-valid source (R6, R8, R5)
        drain_mode = 0;
        fork send(200, 0); join_none
        repeat (100) @(negedge clk);
        chk(occ <= CAP, "R8 occupancy within capacity", occ, CAP);
        chk(occ > CAP - WM, "R6 buffer filled past watermark", occ, CAP - WM + 1);
        chk(max_run == POST, "R6 writes after flag low", max_run, POST);
        chk(dev_wr_n == 1'b1, "R6 strobe idle while stalled", dev_wr_n, 1);
        chk(src_ready == 1'b0, "R2 ready low while flag low", src_ready, 0);
        chk(dev_data == last_acc, "R5 bus holds last word", dev_data, last_acc);
        drain_mode = 1;
        wait fork;

        // Scenario 2: slow drain with a gappy source (R7)
        drain_mode = 2;
        send(300, 30);
        // Scenario 3: packet-commit style emptying (R7, R8)
        drain_mode = 3;
        send(300, 10);

        drain_mode = 1;
        repeat (100) @(negedge clk);
        chk(exp_q.size() == 0, "R7 every accepted word written", exp_q.size(), 0);
        chk(received == sent, "R7 written count equals accepted", received, sent);
        chk(mismatches == 0, "R4 R7 order and values", mismatches, 0);
        chk(overflows == 0, "R8 no write into full buffer", overflows, 0);
        chk(hold_viol == 0, "R5 bus stable on idle cycles", hold_viol, 0);
        chk(max_run <= POST, "R6 stop distance over whole run", max_run, POST);
        chk(occ == 0, "R3 no trailing writes", occ, 0);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule